// File: doc/BRIEF.md
# JTAG Programming Access Guard

This block sits between an already decoded JTAG in-system-programming command stream and a flash memory controller. Each cycle it may receive one command (read, verify, program, sector erase, full chip erase, or one of two output-mode commands). It decides whether the command is allowed, and either forwards it to the flash controller as a one-cycle start pulse or refuses it by raising an error indication. The decision rests on four things: a read-out lock bit, a protect bit for every sector, whether a long flash operation is still running, and whether the port is active at all.

The lock bit and the sector protect bits are loaded from nonvolatile inputs at block reset. While the lock is set, only a full chip erase gets through. When that erase completes, it clears the lock and every protect bit, which leaves the device blank and unsecured. The block drives a ready line and an error line. The command that enables in-system configuration can switch both lines to open-drain style, where they are modelled as output enables that drive only a low level, so several devices can share a wired-OR line.

The port is active in one of two cases. A nonvolatile strap input can dedicate the pins to JTAG, and then the system reset does not affect the port. Otherwise the port is active only while bit 0 of a byte-wide enable register is set. In that case, a system reset clears the register, aborts a running flash operation and refuses to let new commands in.

Top module: `jtag_isp_guard`

## Requirements
- R1: `status` is 1 while no long operation (program, sector erase, chip erase) is running. It is 0 from the cycle after such a command is accepted until the cycle in which `fl_done` is sampled high. It is 1 again on the cycle after that.
- R2: While the lock bit is set, read (op 1), verify (op 2), program (op 3) and sector erase (op 4) are refused. A refused command raises the error and gives no `fl_start`.
- R3: A full chip erase (op 5) is accepted even while locked. When it completes (`fl_done` while busy), the lock bit and all sector protect bits are cleared.
- R4: A sector erase aimed at a protected sector is refused. A program to a protected sector is accepted. Any flash command with a sector index of `NUM_SECTORS` or above, other than chip erase, is refused.
- R5: `err_n` goes low on the cycle after a refused command. It stays low until the cycle after the next accepted command, and then returns high.
- R6: While a long operation is running, every flash command (ops 1 to 5) is refused. This includes a command that arrives in the same cycle as `fl_done`.
- R7: Op 6 with `cmd_od`=1 selects open-drain mode. In that mode `status_oe` is 1 only while `status` is 0, and `err_oe` is 1 only while `err_n` is 0. Op 6 with `cmd_od`=0, or op 7, selects push-pull mode, in which both enables are 1. Ops 6 and 7 are accepted even when locked or busy. Op 0 does nothing.
- R8: Writing the enable register stores only bit 0. `en_rdata` reads bits 7..1 as 0. The register is cleared by `rst_n` low and by `sys_rst_n` low, and a write is ignored while `sys_rst_n` is low.
- R9: When the port is active through the register only and `sys_rst_n` is low, commands are ignored: they give no start pulse and no error. During that time, if an operation is running, `fl_abort` is 1 and the operation ends on the next cycle.
- R10: With `nv_jtag_dedicated`=1, the port stays active and `sys_rst_n` has no effect on commands or running operations.
- R11: `port_active` = `nv_jtag_dedicated` or (enable bit and `sys_rst_n`). Commands are ignored while the port is inactive.
- R12: An accepted flash command (ops 1 to 5) raises `fl_start` in the same cycle, with `fl_op` and `fl_sector` equal to the command's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset; loads the nonvolatile lock and protect inputs |
| sys_rst_n | input | 1 | Active-low system reset seen by the JTAG port |
| nv_jtag_dedicated | input | 1 | Nonvolatile strap that dedicates the pins to JTAG |
| nv_secure | input | 1 | Nonvolatile lock bit, sampled during reset |
| nv_sector_prot | input | NUM_SECTORS | Nonvolatile sector protect bits, sampled during reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data (bit 0 used) |
| en_rdata | output | 8 | Enable register read value |
| port_active | output | 1 | JTAG port currently accepts commands |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 none, 1 read, 2 verify, 3 program, 4 sector erase, 5 chip erase, 6 configuration enable, 7 configuration disable |
| cmd_sector | input | SECT_W | Target sector index |
| cmd_od | input | 1 | Open-drain request carried by op 6 |
| fl_start | output | 1 | One-cycle start pulse to the flash controller |
| fl_op | output | 3 | Operation passed with the start pulse |
| fl_sector | output | SECT_W | Sector passed with the start pulse |
| fl_abort | output | 1 | Abort request for the running operation |
| fl_done | input | 1 | Flash controller reports the running operation finished |
| status | output | 1 | Ready value (1 ready, 0 busy) |
| status_oe | output | 1 | Output enable of the ready line |
| err_n | output | 1 | Error value, active low |
| err_oe | output | 1 | Output enable of the error line |

## Verification
The critical collision happens when a new flash command arrives in the same cycle that the controller reports `fl_done`. The guard must still treat itself as busy, so it refuses the command and raises the error, while the ready line rises on the next cycle. A directed step puts both in one cycle, and a random phase keeps hitting the collision as well as system reset racing a running operation. In every cycle, a behavioural reference model in the bench predicts the start pulse, abort, ready, error and output enables, and these are compared with the design's outputs.

// File: rtl/isp_guard_pkg.sv
// Shared command encoding and helpers for the JTAG programming access guard.
// Assumes the upstream decoder delivers one 3-bit command code per cycle.
package isp_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_READ    = 3'd1,
        OP_VERIFY  = 3'd2,
        OP_PROG    = 3'd3,
        OP_SERASE  = 3'd4,
        OP_CERASE  = 3'd5,
        OP_ISC_ON  = 3'd6,
        OP_ISC_OFF = 3'd7
    } isp_op_e;

    // True for commands that are handed to the flash controller.
    function automatic logic op_uses_flash(isp_op_e op);
        return (op == OP_READ) || (op == OP_VERIFY) || (op == OP_PROG) ||
               (op == OP_SERASE) || (op == OP_CERASE);
    endfunction

    // True for commands that keep the flash busy until done is reported.
    function automatic logic op_is_long(isp_op_e op);
        return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_CERASE);
    endfunction

endpackage

// File: rtl/isp_port_enable.sv
// Port enable register and port activity decision.
// Holds the single live bit of a byte-wide enable register. Both the block
// reset and the system reset clear it. Assumes rst_n and sys_rst_n are
// synchronous to clk.
module isp_port_enable #(
    parameter int EN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sys_rst_n,
    input  logic            nv_dedicated,
    input  logic            wr,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] rdata,
    output logic            active,
    output logic            sys_abort_req
);

    logic en_q;
    logic wdata_spare_unused;

    // Enable bit: cleared by either reset, otherwise loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || !sys_rst_n) begin
            en_q <= 1'b0;
        end else if (wr) begin
            en_q <= wdata[0];
        end
    end

    // Upper write bits are discarded by definition.
    assign wdata_spare_unused = ^wdata[EN_W-1:1];

    // Read view: spare bits always zero.
    always_comb begin
        rdata    = '0;
        rdata[0] = en_q;
    end

    // Port is live when strapped, or when enabled and out of system reset.
    assign active        = nv_dedicated | (en_q & sys_rst_n);
    // System reset may only stop JTAG when the port is not strapped.
    assign sys_abort_req = ~nv_dedicated & ~sys_rst_n;

    a_r8_sysrst_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> (rdata == '0));
    a_r10_strap_keeps_port: assert property (@(posedge clk) disable iff (!rst_n)
        nv_dedicated |-> active);

endmodule

// File: rtl/isp_cmd_filter.sv
// Combinational command admission for the access guard.
// Takes one command per cycle and classifies it as accepted or refused, using
// the lock bit, the sector protect bits and the busy flag. Assumes cmd_take
// is already qualified by port activity and a non-empty opcode.
module isp_cmd_filter
    import isp_guard_pkg::*;
#(
    parameter int NUM_SECTORS = 6,
    parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_take,
    input  isp_op_e                op,
    input  logic [SECT_W-1:0]      sector,
    input  logic                   busy,
    input  logic                   secure,
    input  logic [NUM_SECTORS-1:0] prot,
    output logic                   accept,
    output logic                   reject,
    output logic                   go_flash,
    output logic                   go_long,
    output logic                   go_chip,
    output logic                   isc_on,
    output logic                   isc_off
);

    localparam int PAD = 1 << SECT_W;

    logic [PAD-1:0] prot_pad;
    logic           sector_ok;
    logic           legal;

    // Pad the protect vector so that indices past the last sector read as protected.
    for (genvar i = 0; i < PAD; i++) begin : g_pad
        if (i < NUM_SECTORS) begin : g_real
            assign prot_pad[i] = prot[i];
        end else begin : g_none
            assign prot_pad[i] = 1'b1;
        end
    end

    assign sector_ok = (int'(sector) < NUM_SECTORS);

    // Legality of the presented opcode against lock, busy and protection.
    always_comb begin
        legal = 1'b0;
        unique case (op)
            OP_READ, OP_VERIFY, OP_PROG: legal = !busy && !secure && sector_ok;
            OP_SERASE:                   legal = !busy && !secure && !prot_pad[sector];
            OP_CERASE:                   legal = !busy;
            OP_ISC_ON, OP_ISC_OFF:       legal = 1'b1;
            default:                     legal = 1'b0;
        endcase
    end

    assign accept   = cmd_take & legal;
    assign reject   = cmd_take & ~legal;
    assign go_flash = accept & op_uses_flash(op);
    assign go_long  = accept & op_is_long(op);
    assign go_chip  = accept & (op == OP_CERASE);
    assign isc_on   = accept & (op == OP_ISC_ON);
    assign isc_off  = accept & (op == OP_ISC_OFF);

    a_r2_lock_only_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (go_flash && secure) |-> (op == OP_CERASE));
    a_r4_no_protected_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (go_flash && op == OP_SERASE) |-> (sector_ok && !prot[sector]));
    a_r6_busy_blocks_flash: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !go_flash);

endmodule

// File: rtl/isp_op_tracker.sv
// Operation and security state for the access guard.
// Tracks the running long operation, the lock bit, the sector protect bits
// and the error flag. Assumes fl_done is ignored when nothing is running.
module isp_op_tracker #(
    parameter int NUM_SECTORS = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   nv_secure,
    input  logic [NUM_SECTORS-1:0] nv_prot,
    input  logic                   accept,
    input  logic                   reject,
    input  logic                   go_long,
    input  logic                   go_chip,
    input  logic                   fl_done,
    input  logic                   sys_abort_req,
    output logic                   busy,
    output logic                   secure,
    output logic [NUM_SECTORS-1:0] prot,
    output logic                   err,
    output logic                   abort
);

    logic chip_q;

    assign abort = busy & sys_abort_req;

    // Busy and chip-erase tracking, with unlock on chip-erase completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            chip_q <= 1'b0;
            secure <= nv_secure;
            prot   <= nv_prot;
        end else if (abort) begin
            busy   <= 1'b0;
            chip_q <= 1'b0;
        end else if (busy && fl_done) begin
            busy   <= 1'b0;
            chip_q <= 1'b0;
            if (chip_q) begin
                secure <= 1'b0;
                prot   <= '0;
            end
        end else if (go_long) begin
            busy   <= 1'b1;
            chip_q <= go_chip;
        end
    end

    // Error flag: set by a refusal, cleared by the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (reject) begin
            err <= 1'b1;
        end else if (accept) begin
            err <= 1'b0;
        end
    end

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        go_long |=> busy);
    a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fl_done) |=> !busy);
    a_r3_chip_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chip_q && fl_done && !abort) |=> (!secure && prot == '0));
    a_r5_refusal_flags: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> err);
    a_r9_abort_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

endmodule

// File: rtl/isp_pin_driver.sv
// Ready and error pin drivers for the access guard.
// Holds the open-drain mode bit and forms value and output-enable pairs.
// Assumes the pad drives its value only while the matching enable is high.
module isp_pin_driver (
    input  logic clk,
    input  logic rst_n,
    input  logic isc_on,
    input  logic isc_off,
    input  logic od_req,
    input  logic busy,
    input  logic err,
    output logic status,
    output logic status_oe,
    output logic err_n,
    output logic err_oe
);

    logic od_q;

    // Mode bit: chosen by the configuration enable, dropped by the disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od_q <= 1'b0;
        end else if (isc_on) begin
            od_q <= od_req;
        end else if (isc_off) begin
            od_q <= 1'b0;
        end
    end

    assign status    = ~busy;
    assign err_n     = ~err;
    assign status_oe = od_q ? busy : 1'b1;
    assign err_oe    = od_q ? err  : 1'b1;

    a_r7_busy_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (status_oe && !status));
    a_r7_od_no_high_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (od_q && err_oe) |-> !err_n);

endmodule

// File: rtl/jtag_isp_guard.sv
// JTAG programming access guard, top level.
// Admits decoded programming commands to a flash controller according to the
// lock bit, sector protection, busy state and port enable rules, and drives
// the ready and error lines. Assumes all inputs are synchronous to clk.
module jtag_isp_guard
    import isp_guard_pkg::*;
#(
    parameter int NUM_SECTORS = 6,
    parameter int SECT_W      = $clog2(NUM_SECTORS),
    parameter int EN_W        = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sys_rst_n,
    input  logic                   nv_jtag_dedicated,
    input  logic                   nv_secure,
    input  logic [NUM_SECTORS-1:0] nv_sector_prot,
    input  logic                   en_wr,
    input  logic [EN_W-1:0]        en_wdata,
    output logic [EN_W-1:0]        en_rdata,
    output logic                   port_active,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_op,
    input  logic [SECT_W-1:0]      cmd_sector,
    input  logic                   cmd_od,
    output logic                   fl_start,
    output logic [2:0]             fl_op,
    output logic [SECT_W-1:0]      fl_sector,
    output logic                   fl_abort,
    input  logic                   fl_done,
    output logic                   status,
    output logic                   status_oe,
    output logic                   err_n,
    output logic                   err_oe
);

    isp_op_e                op;
    logic                   take;
    logic                   sys_abort_req;
    logic                   accept, reject, go_flash, go_long, go_chip;
    logic                   isc_on, isc_off;
    logic                   busy, secure, err;
    logic [NUM_SECTORS-1:0] prot;

    assign op   = isp_op_e'(cmd_op);
    assign take = cmd_valid & port_active & (op != OP_NOP);

    isp_port_enable #(.EN_W(EN_W)) u_enable (
        .clk           (clk),
        .rst_n         (rst_n),
        .sys_rst_n     (sys_rst_n),
        .nv_dedicated  (nv_jtag_dedicated),
        .wr            (en_wr),
        .wdata         (en_wdata),
        .rdata         (en_rdata),
        .active        (port_active),
        .sys_abort_req (sys_abort_req)
    );

    isp_cmd_filter #(.NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_take (take),
        .op       (op),
        .sector   (cmd_sector),
        .busy     (busy),
        .secure   (secure),
        .prot     (prot),
        .accept   (accept),
        .reject   (reject),
        .go_flash (go_flash),
        .go_long  (go_long),
        .go_chip  (go_chip),
        .isc_on   (isc_on),
        .isc_off  (isc_off)
    );

    isp_op_tracker #(.NUM_SECTORS(NUM_SECTORS)) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .nv_secure     (nv_secure),
        .nv_prot       (nv_sector_prot),
        .accept        (accept),
        .reject        (reject),
        .go_long       (go_long),
        .go_chip       (go_chip),
        .fl_done       (fl_done),
        .sys_abort_req (sys_abort_req),
        .busy          (busy),
        .secure        (secure),
        .prot          (prot),
        .err           (err),
        .abort         (fl_abort)
    );

    isp_pin_driver u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .isc_on    (isc_on),
        .isc_off   (isc_off),
        .od_req    (cmd_od),
        .busy      (busy),
        .err       (err),
        .status    (status),
        .status_oe (status_oe),
        .err_n     (err_n),
        .err_oe    (err_oe)
    );

    assign fl_start  = go_flash;
    assign fl_op     = cmd_op;
    assign fl_sector = cmd_sector;

    a_r12_start_is_accept: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start |-> (port_active && cmd_valid));
    a_r11_idle_port_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !port_active |-> !fl_start);

endmodule

// File: tb/jtag_isp_guard_tb.sv
// Testbench: a behavioural reference model is compared with the guard in every cycle.
module jtag_isp_guard_tb;

    localparam int NS = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n, sys_rst_n, nv_ded, nv_secure;
    logic [NS-1:0] nv_prot;
    logic          en_wr;
    logic [7:0]    en_wdata, en_rdata;
    logic          port_active;
    logic          cmd_valid, cmd_od;
    logic [2:0]    cmd_op, fl_op;
    logic [SW-1:0] cmd_sector, fl_sector;
    logic          fl_start, fl_abort, fl_done;
    logic          status, status_oe, err_n, err_oe;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // Reference model state
    bit          m_busy, m_chip, m_secure, m_err, m_od, m_en;
    bit [NS-1:0] m_prot;

    always #4 clk = ~clk;

    jtag_isp_guard u_dut (
        .clk(clk), .rst_n(rst_n), .sys_rst_n(sys_rst_n),
        .nv_jtag_dedicated(nv_ded), .nv_secure(nv_secure),
        .nv_sector_prot(nv_prot), .en_wr(en_wr), .en_wdata(en_wdata),
        .en_rdata(en_rdata), .port_active(port_active),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sector(cmd_sector),
        .cmd_od(cmd_od), .fl_start(fl_start), .fl_op(fl_op),
        .fl_sector(fl_sector), .fl_abort(fl_abort), .fl_done(fl_done),
        .status(status), .status_oe(status_oe), .err_n(err_n), .err_oe(err_oe)
    );

    function automatic bit m_active();
        return nv_ded || (m_en && sys_rst_n);
    endfunction

    function automatic bit m_take();
        return cmd_valid && m_active() && (cmd_op != 3'd0);
    endfunction

    function automatic bit m_legal();
        bit sec_ok = (int'(cmd_sector) < NS);
        case (cmd_op)
            3'd1, 3'd2, 3'd3: return !m_busy && !m_secure && sec_ok;
            3'd4:             return !m_busy && !m_secure && sec_ok && !m_prot[cmd_sector];
            3'd5:             return !m_busy;
            3'd6, 3'd7:       return 1'b1;
            default:          return 1'b0;
        endcase
    endfunction

    task automatic chk(string name, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit acc    = m_take() && m_legal();
        bit xstart = acc && (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
        chk("port_active", {7'b0, port_active}, {7'b0, m_active()});
        chk("fl_start", {7'b0, fl_start}, {7'b0, xstart});
        if (xstart) begin
            chk("fl_op", {5'b0, fl_op}, {5'b0, cmd_op});
            chk("fl_sector", {5'b0, fl_sector}, {5'b0, cmd_sector});
        end
        chk("fl_abort", {7'b0, fl_abort}, {7'b0, m_busy && !nv_ded && !sys_rst_n});
        chk("status", {7'b0, status}, {7'b0, !m_busy});
        chk("status_oe", {7'b0, status_oe}, {7'b0, m_od ? m_busy : 1'b1});
        chk("err_n", {7'b0, err_n}, {7'b0, !m_err});
        chk("err_oe", {7'b0, err_oe}, {7'b0, m_od ? m_err : 1'b1});
        chk("en_rdata", en_rdata, {7'b0, m_en});
    endtask

    task automatic model_update();
        bit acc = m_take() && m_legal();
        bit rej = m_take() && !m_legal();
        if (!rst_n) begin
            m_busy = 0; m_chip = 0; m_err = 0; m_od = 0; m_en = 0;
            m_secure = nv_secure; m_prot = nv_prot;
            return;
        end
        if (m_busy && !nv_ded && !sys_rst_n) begin
            m_busy = 0; m_chip = 0;
        end else if (m_busy && fl_done) begin
            m_busy = 0;
            if (m_chip) begin m_secure = 0; m_prot = '0; end
            m_chip = 0;
        end else if (acc && cmd_op >= 3'd3 && cmd_op <= 3'd5) begin
            m_busy = 1; m_chip = (cmd_op == 3'd5);
        end
        if (rej) m_err = 1;
        else if (acc) m_err = 0;
        if (acc && cmd_op == 3'd6) m_od = cmd_od;
        else if (acc && cmd_op == 3'd7) m_od = 0;
        if (!sys_rst_n) m_en = 0;
        else if (en_wr) m_en = en_wdata[0];
    endtask

    task automatic tick();
        #2 compare();
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
    endtask

    task automatic idle_in();
        cmd_valid = 0; cmd_op = 0; cmd_sector = 0; cmd_od = 0;
        en_wr = 0; en_wdata = 0; fl_done = 0;
    endtask

    task automatic issue(input logic [2:0] op, input logic [SW-1:0] sec, input logic od);
        cmd_valid = 1; cmd_op = op; cmd_sector = sec; cmd_od = od;
        tick();
        cmd_valid = 0; cmd_op = 0;
    endtask

    task automatic done_pulse();
        fl_done = 1; tick(); fl_done = 0;
    endtask

    task automatic do_reset(input logic sec, input logic [NS-1:0] pr, input logic ded);
        nv_secure = sec; nv_prot = pr; nv_ded = ded;
        rst_n = 0; tick(); tick(); rst_n = 1;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        idle_in();
        sys_rst_n = 1;
        @(negedge clk);
        cur_req = "R8";
        do_reset(1'b0, 6'b000100, 1'b0);
        tick();
        // R11: port disabled, command ignored
        cur_req = "R11";
        issue(3'd1, 3'd0, 1'b0);
        // R8: write all ones, only bit 0 kept
        cur_req = "R8";
        en_wr = 1; en_wdata = 8'hFF; tick(); en_wr = 0;
        tick();
        // R12: read accepted
        cur_req = "R12";
        issue(3'd1, 3'd1, 1'b0);
        // R4: program a protected sector is allowed; R1 busy
        cur_req = "R4";
        issue(3'd3, 3'd2, 1'b0);
        cur_req = "R1";
        tick();
        // R6: command while busy refused
        cur_req = "R6";
        issue(3'd4, 3'd3, 1'b0);
        // R6: command in same cycle as done refused
        fl_done = 1; issue(3'd1, 3'd0, 1'b0); fl_done = 0;
        cur_req = "R1";
        tick();
        // R4: protected and out-of-range erase refused
        cur_req = "R4";
        issue(3'd4, 3'd2, 1'b0);
        issue(3'd4, 3'd7, 1'b0);
        issue(3'd1, 3'd6, 1'b0);
        // R5: accepted erase clears error
        cur_req = "R5";
        issue(3'd4, 3'd3, 1'b0);
        tick();
        done_pulse();
        // R7: open-drain mode
        cur_req = "R7";
        issue(3'd6, 3'd0, 1'b1);
        issue(3'd3, 3'd0, 1'b0);
        issue(3'd3, 3'd0, 1'b0);
        issue(3'd7, 3'd0, 1'b0);
        issue(3'd6, 3'd0, 1'b1);
        done_pulse();
        issue(3'd6, 3'd0, 1'b0);
        issue(3'd0, 3'd0, 1'b0);
        // R9: system reset aborts register-enabled port
        cur_req = "R9";
        issue(3'd3, 3'd1, 1'b0);
        sys_rst_n = 0; tick();
        issue(3'd1, 3'd1, 1'b0);
        en_wr = 1; en_wdata = 8'h01; tick(); en_wr = 0;
        sys_rst_n = 1; tick();
        cur_req = "R11";
        issue(3'd1, 3'd1, 1'b0);
        // R10/R2: strapped, locked
        cur_req = "R2";
        do_reset(1'b1, 6'b110000, 1'b1);
        issue(3'd1, 3'd0, 1'b0);
        issue(3'd2, 3'd0, 1'b0);
        issue(3'd3, 3'd0, 1'b0);
        issue(3'd4, 3'd0, 1'b0);
        cur_req = "R3";
        issue(3'd5, 3'd0, 1'b0);
        cur_req = "R10";
        sys_rst_n = 0; tick(); tick();
        issue(3'd1, 3'd0, 1'b0);
        sys_rst_n = 1;
        cur_req = "R3";
        done_pulse();
        issue(3'd1, 3'd0, 1'b0);
        issue(3'd4, 3'd5, 1'b0);
        done_pulse();
        // Random phase
        cur_req = "R6";
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            if (k == 200) begin
                do_reset(1'b1, 6'b001010, 1'b0);
                en_wr = 1; en_wdata = 8'h01; tick();
            end
            cmd_valid  = lfsr[0];
            cmd_op     = lfsr[3:1];
            cmd_sector = lfsr[6:4];
            cmd_od     = lfsr[7];
            fl_done    = lfsr[8] & lfsr[9];
            sys_rst_n  = ~(lfsr[10] & lfsr[11] & lfsr[12]);
            en_wr      = lfsr[13] & lfsr[14];
            en_wdata   = {7'b0, ~lfsr[15]};
            tick();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        idle_in();
        sys_rst_n = 1;
        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule